// File: doc/BRIEF.md
# Write-Masked GPIO Port Register File

This block holds the software-visible state of a 32-pin general-purpose I/O port and drives the pad controls from it. Each logical 32-bit register is reached through two bus words. The word at the register's base offset covers pins 0-15. The word at base plus 4 covers pins 16-31. On a write, the upper sixteen bits of the bus word select which of the lower sixteen data bits are taken. Software can therefore set or clear any single pin with one write, with no read-modify-write sequence and no lock.

The output-value register drives `pad_out`, and the direction register drives `pad_oe`. The pin levels pass through a two-flop synchronizer and can be read back from a read-only input register. A read-only identification word lets software detect this register layout. Reads are registered: the value appears on `bus_rdata` after the clock edge that accepts the read, and it holds until the next read.

Top module: `gpio_wm_port`

## Requirements
- R1: A write to the low word of a writable register (output value at 0x00, direction at 0x08) changes bit i of pins 0-15 to wdata[i] only when wdata[16+i] is 1. Every other bit keeps its value, and the new value is visible after that clock edge.
- R2: Pins 16-31 of each writable register are reached through the word at base offset plus 4 (0x04 and 0x0C). They use the same per-bit enable rule: wdata[16+i] enables pin 16+i to take wdata[i].
- R3: `pad_out` equals the output-value register. It changes only on write cycles to 0x00 or 0x04.
- R4: `pad_oe` equals the direction register. A 1 makes the pin an output and a 0 makes it an input.
- R5: Reset (rst_n low) clears the output-value and direction registers, so every pin starts as an input driving 0.
- R6: A read of 0x00, 0x04, 0x08 or 0x0C returns that pin half in bits [15:0] and zero in bits [31:16].
- R7: The input register shows `pin_in` after a two-flop synchronizer. Pins 0-15 are read at 0x70 and pins 16-31 at 0x74, with zero in bits [31:16]. Writes there have no effect.
- R8: A read of 0x78 returns 0x01000C2B. Writes there have no effect.
- R9: A read of any other byte address, including misaligned ones, returns zero. A write to any such address changes neither pad output.
- R10: `bus_rdata` is loaded on the clock edge of an accepted read (bus_en=1, bus_wr=0). On all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Registered read word |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables (1 = drive) |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around the clock edge whenever `bus_en` is high. The input-register check also assumes that `pin_in` settles well before an edge, so the synchronizer latency is exactly two edges. The stimulus changes all bus signals and pins only at falling edges and holds them for a full cycle. It also waits three cycles after changing a pin before reading it back, so it stays within these assumptions.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;

    localparam int          ADDR_W       = 8;
    localparam logic [7:0]  OFS_OUTVAL   = 8'h00;
    localparam logic [7:0]  OFS_DIRN     = 8'h08;
    localparam logic [7:0]  OFS_PINLVL   = 8'h70;
    localparam logic [7:0]  OFS_IDENT    = 8'h78;
    localparam logic [7:0]  HI_STEP      = 8'h04;
    localparam logic [31:0] IDENT_WORD   = 32'h01000C2B;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OUTVAL,
        TGT_DIRN,
        TGT_PINLVL,
        TGT_IDENT
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic hi;
    } dec_t;

    function automatic dec_t addr_decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.tgt = TGT_NONE;
        d.hi  = 1'b0;
        if (a == OFS_OUTVAL)                 d.tgt = TGT_OUTVAL;
        else if (a == OFS_OUTVAL + HI_STEP)  begin d.tgt = TGT_OUTVAL; d.hi = 1'b1; end
        else if (a == OFS_DIRN)              d.tgt = TGT_DIRN;
        else if (a == OFS_DIRN + HI_STEP)    begin d.tgt = TGT_DIRN;   d.hi = 1'b1; end
        else if (a == OFS_PINLVL)            d.tgt = TGT_PINLVL;
        else if (a == OFS_PINLVL + HI_STEP)  begin d.tgt = TGT_PINLVL; d.hi = 1'b1; end
        else if (a == OFS_IDENT)             d.tgt = TGT_IDENT;
        return d;
    endfunction

endpackage

// File: rtl/gpio_wm_mreg.sv
module gpio_wm_mreg #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wr_half,
    input  logic [2*HALF_W-1:0] wword,
    output logic [2*HALF_W-1:0] q
);
    localparam int PINS = 2 * HALF_W;

    logic [HALF_W-1:0] en_bits;
    logic [HALF_W-1:0] val_bits;

    assign en_bits  = wword[PINS-1:HALF_W];
    assign val_bits = wword[HALF_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (wr_half[h]) begin
                    q[h*HALF_W +: HALF_W] <= (q[h*HALF_W +: HALF_W] & ~en_bits)
                                           | (val_bits & en_bits);
                end
            end
        end
    end
endmodule

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_wm_rdmux.sv
module gpio_wm_rdmux
    import gpio_wm_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  dec_t                sel,
    input  logic [2*HALF_W-1:0] outval,
    input  logic [2*HALF_W-1:0] dirn,
    input  logic [2*HALF_W-1:0] pinlvl,
    output logic [2*HALF_W-1:0] word
);
    localparam int PINS = 2 * HALF_W;

    function automatic logic [PINS-1:0] pick(input logic [PINS-1:0] r, input logic hi);
        return hi ? {{HALF_W{1'b0}}, r[PINS-1:HALF_W]} : {{HALF_W{1'b0}}, r[HALF_W-1:0]};
    endfunction

    always_comb begin
        unique case (sel.tgt)
            TGT_OUTVAL: word = pick(outval, sel.hi);
            TGT_DIRN:   word = pick(dirn, sel.hi);
            TGT_PINLVL: word = pick(pinlvl, sel.hi);
            TGT_IDENT:  word = PINS'(IDENT_WORD);
            default:    word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_wm_port.sv
module gpio_wm_port
    import gpio_wm_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic [2*HALF_W-1:0] pin_in,
    output logic [2*HALF_W-1:0] pad_out,
    output logic [2*HALF_W-1:0] pad_oe
);
    localparam int PINS = 2 * HALF_W;

    dec_t            dec;
    logic            wr_cyc;
    logic            rd_cyc;
    logic [1:0]      wr_out;
    logic [1:0]      wr_dir;
    logic [PINS-1:0] outval_q;
    logic [PINS-1:0] dirn_q;
    logic [PINS-1:0] pinlvl_q;
    logic [PINS-1:0] rd_word;

    assign dec    = addr_decode(bus_addr);
    assign wr_cyc = bus_en & bus_wr;
    assign rd_cyc = bus_en & ~bus_wr;

    assign wr_out = {wr_cyc && dec.tgt == TGT_OUTVAL &&  dec.hi,
                     wr_cyc && dec.tgt == TGT_OUTVAL && !dec.hi};
    assign wr_dir = {wr_cyc && dec.tgt == TGT_DIRN &&  dec.hi,
                     wr_cyc && dec.tgt == TGT_DIRN && !dec.hi};

    gpio_wm_mreg #(.HALF_W(HALF_W)) u_outval (
        .clk(clk), .rst_n(rst_n), .wr_half(wr_out), .wword(bus_wdata), .q(outval_q));

    gpio_wm_mreg #(.HALF_W(HALF_W)) u_dirn (
        .clk(clk), .rst_n(rst_n), .wr_half(wr_dir), .wword(bus_wdata), .q(dirn_q));

    gpio_wm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pinlvl_q));

    gpio_wm_rdmux #(.HALF_W(HALF_W)) u_rdmux (
        .sel(dec), .outval(outval_q), .dirn(dirn_q), .pinlvl(pinlvl_q), .word(rd_word));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_cyc) bus_rdata <= rd_word;
    end

    assign pad_out = outval_q;
    assign pad_oe  = dirn_q;
endmodule

// File: rtl/gpio_wm_port_chk.sv
module gpio_wm_port_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_wr,
    input logic [7:0]          bus_addr,
    input logic [2*HALF_W-1:0] bus_wdata,
    input logic [2*HALF_W-1:0] bus_rdata,
    input logic [2*HALF_W-1:0] pin_in,
    input logic [2*HALF_W-1:0] pad_out,
    input logic [2*HALF_W-1:0] pad_oe
);
    localparam int PINS = 2 * HALF_W;

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    logic wr, rd;
    assign wr = bus_en & bus_wr;
    assign rd = bus_en & ~bus_wr;

    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0));

    a_r1_low_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h00) |=> pad_out[HALF_W-1:0] ==
            (($past(pad_out[HALF_W-1:0]) & ~$past(bus_wdata[PINS-1:HALF_W]))
           | ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[PINS-1:HALF_W]))));

    a_r2_high_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h04) |=> pad_out[PINS-1:HALF_W] ==
            (($past(pad_out[PINS-1:HALF_W]) & ~$past(bus_wdata[PINS-1:HALF_W]))
           | ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[PINS-1:HALF_W]))));

    a_r4_dir_low_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h08) |=> pad_oe[HALF_W-1:0] ==
            (($past(pad_oe[HALF_W-1:0]) & ~$past(bus_wdata[PINS-1:HALF_W]))
           | ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[PINS-1:HALF_W]))));

    a_r3_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == 8'h00 || bus_addr == 8'h04)) |=> $stable(pad_out));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[7:4] == 4'h0 && bus_addr[1:0] == 2'b00)
            |=> bus_rdata[PINS-1:HALF_W] == '0);

    a_r7_pin_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 8'h70 && age == 3)
            |=> bus_rdata[HALF_W-1:0] == $past(pin_in[HALF_W-1:0], 3));

    a_r8_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 8'h78) |=> bus_rdata == PINS'(32'h01000C2B));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[7]) |=> bus_rdata == '0);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

bind gpio_wm_port gpio_wm_port_chk #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe));

// File: tb/gpio_wm_port_bench.sv
`timescale 1ns/1ps
module gpio_wm_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        fired = 1'b0;

    always #4 clk = ~clk;

    gpio_wm_port u_gpio_wm_port (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(input logic [31:0] r, input logic [31:0] w, input bit hi);
        logic [15:0] h;
        h = hi ? r[31:16] : r[15:0];
        h = (h & ~w[31:16]) | (w[15:0] & w[31:16]);
        return hi ? {h, r[15:0]} : {r[31:16], h};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] w);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        if (a == 8'h00) m_out = apply(m_out, w, 1'b0);
        if (a == 8'h04) m_out = apply(m_out, w, 1'b1);
        if (a == 8'h08) m_dir = apply(m_dir, w, 1'b0);
        if (a == 8'h0C) m_dir = apply(m_dir, w, 1'b1);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    always @(posedge clk) fired <= bus_en && !bus_wr && rst_n;

    always @(negedge clk) begin
        if (fired) begin
            if (exp_q.size() == 0) begin
                check("monitor queue empty", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic check_pads(input string tag);
        @(negedge clk);
        check({tag, " pad_out"}, pad_out, m_out);
        check({tag, " pad_oe"}, pad_oe, m_dir);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_pads("R5 reset state");
        bus_read(8'h00, 32'h0, "R5 R6 outval low after reset");
        bus_read(8'h0C, 32'h0, "R5 R6 dirn high after reset");
        bus_read(8'h78, 32'h01000C2B, "R8 ident word");

        bus_write(8'h00, 32'h00FF_A5A5);
        check_pads("R1 low byte enabled");
        bus_write(8'h00, 32'h0000_FFFF);
        check_pads("R1 zero enables no change");
        bus_write(8'h00, 32'h8101_0000);
        check_pads("R1 single-bit clears");
        bus_read(8'h00, {16'h0, m_out[15:0]}, "R6 R1 outval low readback");

        bus_write(8'h04, 32'h8001_FFFF);
        check_pads("R2 R3 high half pins 16 and 31");
        bus_read(8'h04, 32'h0000_8001, "R2 R6 outval high readback");

        bus_write(8'h08, 32'hFFFF_1234);
        bus_write(8'h0C, 32'h00F0_5A5A);
        check_pads("R4 direction both halves");
        bus_read(8'h08, 32'h0000_1234, "R4 R6 dirn low readback");
        bus_read(8'h0C, {16'h0, m_dir[31:16]}, "R4 R6 dirn high readback");

        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        bus_read(8'h70, 32'h0000_BEEF, "R7 pin level low");
        bus_read(8'h74, 32'h0000_DEAD, "R7 pin level high");
        bus_write(8'h70, 32'hFFFF_0000);
        bus_read(8'h70, 32'h0000_BEEF, "R7 write to input ignored");
        pin_in = 32'h0001_8000;
        repeat (3) @(negedge clk);
        bus_read(8'h74, 32'h0000_0001, "R7 pin level high second pattern");
        bus_read(8'h70, 32'h0000_8000, "R7 pin level low second pattern");

        bus_write(8'h78, 32'hFFFF_FFFF);
        bus_read(8'h78, 32'h01000C2B, "R8 ident after write");

        bus_read(8'h7C, 32'h0, "R9 read 0x7C");
        bus_read(8'h40, 32'h0, "R9 read 0x40");
        bus_read(8'h01, 32'h0, "R9 misaligned read");
        bus_read(8'hF0, 32'h0, "R9 high read");
        bus_write(8'h10, 32'hFFFF_0000);
        bus_write(8'h02, 32'hFFFF_0000);
        check_pads("R9 unmapped writes no effect");

        bus_read(8'h78, 32'h01000C2B, "R10 read before hold");
        repeat (2) @(negedge clk);
        check("R10 rdata holds while idle", bus_rdata, 32'h01000C2B);
        bus_write(8'h00, 32'hFFFF_0000);
        check("R10 rdata holds over write", bus_rdata, 32'h01000C2B);

        @(negedge clk);
        rst_n = 1'b0;
        m_out = '0; m_dir = '0;
        @(negedge clk);
        check_pads("R5 reset mid-run");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule